// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure held in memory. A root register names the 4 KB page that holds the first-level table. The top ten address bits select a first-level entry, the next ten select a second-level entry inside the page that the first-level entry names, and the low twelve bits pass through unchanged as the offset within the final 4 KB page.

A walk starts when the requester presents an address together with its access kind (read or write) and its mode (user or supervisor). The walker fetches the two entries one word read at a time, checks that each is present and that it allows the access, and then marks the entries as used: the accessed flag in both entries, and the dirty flag in the second-level entry when the access is a write. It answers with a one-cycle response carrying either the physical address or a fault with a four-bit cause. The root register can be loaded only by a requester running at the most privileged ring.

Top module: `pt_walker`

## Requirements
- R1: The first-level entry is read from the word at root + 4 × address bits 31:22; the root register resets to zero and holds a 4 KB aligned value.
- R2: The second-level entry is read from the word at (first-level bits 31:12 × 4096) + 4 × address bits 21:12; a successful walk returns second-level bits 31:12 joined with address bits 11:0.
- R3: An entry whose bit 0 (present) is clear, at either level, ends the walk in a fault with no further reads.
- R4: A user-mode access faults when bit 2 (user) is clear in the entry at either level.
- R5: A user-mode write faults when bit 1 (writable) is clear at either level; supervisor accesses ignore bits 1 and 2.
- R6: The fault cause is {bit 3: fault found at second level, bit 2: user access, bit 1: write access, bit 0: entry was present (protection) rather than missing}; a successful walk returns cause 0 and fault low.
- R7: After a successful walk, each entry whose bit 5 (accessed) was clear is rewritten with bit 5 set, first-level entry first.
- R8: After a successful write walk the second-level entry carries bit 6 (dirty) set; a read walk leaves bit 6 unchanged.
- R9: A faulting walk writes nothing to memory.
- R10: A root register load takes effect only when the requester ring is 0; at any other ring it is ignored.
- R11: At most one memory read is outstanding, reads and writes never overlap, the response is a single-cycle pulse, and a new request is accepted only while idle.
- R12: After reset the walker is idle and ready, with no memory access and no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_we | input | 1 | Request to load the root register |
| root_wdata | input | 32 | New root value (bits 11:0 dropped) |
| cur_ring | input | 2 | Privilege ring of the requester |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_rd_en | output | 1 | One-cycle word read request |
| mem_wr_en | output | 1 | One-cycle word write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry value |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| resp_valid | output | 1 | Walk finished (one cycle) |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_code | output | 4 | Fault cause |
| resp_paddr | output | 32 | Physical address on success |

## Verification
The walk is tried with supervisor and user reads and writes against entries that differ in one flag at a time, so each outcome separates which level's present, user or writable bit decided it. Addresses that miss at the first level are set against ones that miss only at the second, which the level bit of the cause tells apart. Memory is read back after walks to separate reads (accessed only) from writes (accessed and dirty) and from faulting walks (untouched), and the root register is loaded at ring 3 and ring 0 to show that only the second load redirects the walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_CHK_DIR,
    ST_RD_TBL,
    ST_CHK_TBL,
    ST_WB,
    ST_DONE
  } walk_state_t;

  // entry flag positions
  localparam int FL_PRES  = 0;
  localparam int FL_WR    = 1;
  localparam int FL_USR   = 2;
  localparam int FL_ACC   = 5;
  localparam int FL_DIRTY = 6;

  typedef struct packed {
    logic at_table;
    logic user;
    logic write;
    logic prot;
  } fault_code_t;

endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walk_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_user,
  input  logic               is_write,
  output logic               present,
  output logic               allowed
);

  logic deny_user;
  logic deny_write;

  always_comb begin
    present    = entry[FL_PRES];
    deny_user  = is_user && !entry[FL_USR];
    deny_write = is_user && is_write && !entry[FL_WR];
    allowed    = present && !deny_user && !deny_write;
  end

endmodule

// File: rtl/pt_root_reg.sv
module pt_root_reg #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int RING_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RING_W-1:0] ring,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] root_q
);

  logic              load_en;
  logic [ADDR_W-1:0] root_d;

  always_comb begin
    load_en = we && (ring == '0);
    root_d  = {wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
    end else if (load_en) begin
      root_q <= root_d;
    end
  end

  a_r10_ring_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ring != '0) |=> $stable(root_q));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int RING_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [ADDR_W-1:0] root_wdata,
  input  logic [RING_W-1:0] cur_ring,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [3:0]        resp_code,
  output logic [ADDR_W-1:0] resp_paddr
);

  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int PAD_W   = ADDR_W - IDX_W - 2;

  walk_state_t       state_q, state_d;
  logic              issued_q, issued_d;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic              wr_q, wr_d, usr_q, usr_d;
  logic [ADDR_W-1:0] pde_q, pde_d, pte_q, pte_d;
  logic [ADDR_W-1:0] pde_addr_q, pde_addr_d, pte_addr_q, pte_addr_d;
  logic              pde_pend_q, pde_pend_d, pte_pend_q, pte_pend_d;
  logic              fault_q, fault_d;
  fault_code_t       code_q, code_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;

  logic [ADDR_W-1:0] root_q;
  logic [ADDR_W-1:0] dir_off, tbl_off;
  logic              dir_present, dir_ok, tbl_present, tbl_ok;

  pt_root_reg #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .RING_W(RING_W)
  ) u_root (
    .clk(clk), .rst_n(rst_n), .we(root_we), .ring(cur_ring),
    .wdata(root_wdata), .root_q(root_q)
  );

  pt_entry_check #(.ENTRY_W(ADDR_W)) u_chk_dir (
    .entry(pde_q), .is_user(usr_q), .is_write(wr_q),
    .present(dir_present), .allowed(dir_ok)
  );

  pt_entry_check #(.ENTRY_W(ADDR_W)) u_chk_tbl (
    .entry(pte_q), .is_user(usr_q), .is_write(wr_q),
    .present(tbl_present), .allowed(tbl_ok)
  );

  assign dir_off = {{PAD_W{1'b0}}, req_addr[ADDR_W-1 -: IDX_W], 2'b00};
  assign tbl_off = {{PAD_W{1'b0}}, vaddr_q[OFF_W +: IDX_W], 2'b00};

  // next-state process
  always_comb begin
    state_d    = state_q;
    issued_d   = issued_q;
    vaddr_d    = vaddr_q;
    wr_d       = wr_q;
    usr_d      = usr_q;
    pde_d      = pde_q;
    pte_d      = pte_q;
    pde_addr_d = pde_addr_q;
    pte_addr_d = pte_addr_q;
    pde_pend_d = pde_pend_q;
    pte_pend_d = pte_pend_q;
    fault_d    = fault_q;
    code_d     = code_q;
    paddr_d    = paddr_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          vaddr_d    = req_addr;
          wr_d       = req_write;
          usr_d      = req_user;
          pde_addr_d = root_q + dir_off;
          fault_d    = 1'b0;
          code_d     = '0;
          paddr_d    = '0;
          pde_pend_d = 1'b0;
          pte_pend_d = 1'b0;
          issued_d   = 1'b0;
          state_d    = ST_RD_DIR;
        end
      end
      ST_RD_DIR: begin
        if (!issued_q) begin
          issued_d = 1'b1;
        end else if (mem_rvalid) begin
          pde_d    = mem_rdata;
          issued_d = 1'b0;
          state_d  = ST_CHK_DIR;
        end
      end
      ST_CHK_DIR: begin
        if (!dir_ok) begin
          fault_d = 1'b1;
          code_d  = '{at_table: 1'b0, user: usr_q, write: wr_q, prot: dir_present};
          state_d = ST_DONE;
        end else begin
          pte_addr_d = {pde_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + tbl_off;
          state_d    = ST_RD_TBL;
        end
      end
      ST_RD_TBL: begin
        if (!issued_q) begin
          issued_d = 1'b1;
        end else if (mem_rvalid) begin
          pte_d    = mem_rdata;
          issued_d = 1'b0;
          state_d  = ST_CHK_TBL;
        end
      end
      ST_CHK_TBL: begin
        if (!tbl_ok) begin
          fault_d = 1'b1;
          code_d  = '{at_table: 1'b1, user: usr_q, write: wr_q, prot: tbl_present};
          state_d = ST_DONE;
        end else begin
          paddr_d    = {pte_q[ADDR_W-1 -: FRAME_W], vaddr_q[OFF_W-1:0]};
          pde_pend_d = !pde_q[FL_ACC];
          pte_pend_d = !pte_q[FL_ACC] || (wr_q && !pte_q[FL_DIRTY]);
          if (!pde_q[FL_ACC] || !pte_q[FL_ACC] || (wr_q && !pte_q[FL_DIRTY])) begin
            state_d = ST_WB;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_WB: begin
        if (pde_pend_q) begin
          pde_pend_d = 1'b0;
          if (!pte_pend_q) state_d = ST_DONE;
        end else begin
          pte_pend_d = 1'b0;
          state_d    = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      issued_q   <= 1'b0;
      vaddr_q    <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      pde_q      <= '0;
      pte_q      <= '0;
      pde_addr_q <= '0;
      pte_addr_q <= '0;
      pde_pend_q <= 1'b0;
      pte_pend_q <= 1'b0;
      fault_q    <= 1'b0;
      code_q     <= '0;
      paddr_q    <= '0;
    end else begin
      state_q    <= state_d;
      issued_q   <= issued_d;
      vaddr_q    <= vaddr_d;
      wr_q       <= wr_d;
      usr_q      <= usr_d;
      pde_q      <= pde_d;
      pte_q      <= pte_d;
      pde_addr_q <= pde_addr_d;
      pte_addr_q <= pte_addr_d;
      pde_pend_q <= pde_pend_d;
      pte_pend_q <= pte_pend_d;
      fault_q    <= fault_d;
      code_q     <= code_d;
      paddr_q    <= paddr_d;
    end
  end

  // outputs
  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    mem_rd_en  = ((state_q == ST_RD_DIR) || (state_q == ST_RD_TBL)) && !issued_q;
    mem_wr_en  = (state_q == ST_WB) && (pde_pend_q || pte_pend_q);
    mem_addr   = pte_addr_q;
    mem_wdata  = pte_q | (ADDR_W'(1) << FL_ACC) | (ADDR_W'(wr_q) << FL_DIRTY);
    if (state_q == ST_RD_DIR || (state_q == ST_WB && pde_pend_q)) begin
      mem_addr = pde_addr_q;
    end
    if (state_q == ST_WB && pde_pend_q) begin
      mem_wdata = pde_q | (ADDR_W'(1) << FL_ACC);
    end
    resp_valid = (state_q == ST_DONE);
    resp_fault = fault_q;
    resp_code  = code_q;
    resp_paddr = paddr_q;
  end

  a_r11_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r11_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r7_wb_marks_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[FL_ACC]);
  a_r9_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !fault_q);
  a_r6_success_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_code == 4'h0));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        root_we;
  logic [31:0] root_wdata;
  logic [1:0]  cur_ring;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_addr;
  logic        mem_rd_en, mem_wr_en, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        resp_valid, resp_fault;
  logic [3:0]  resp_code;
  logic [31:0] resp_paddr;

  int total = 0;
  int bad   = 0;

  logic [31:0] mem [2048];

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .cur_ring(cur_ring), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_code(resp_code),
    .resp_paddr(resp_paddr)
  );

  // memory model: one-cycle read latency, writes take effect at the edge
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd_en) begin
      mem_rdata  <= mem[mem_addr[12:2]];
      mem_rvalid <= 1'b1;
    end
    if (mem_wr_en) mem[mem_addr[12:2]] <= mem_wdata;
  end

  typedef struct packed {
    logic [31:0] la;
    logic        wr;
    logic        usr;
    logic        fault;
    logic [3:0]  code;
    logic [31:0] pa;
  } vec_t;

  // code = {table level, user, write, present}
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'hF1084150, 1'b0, 1'b0, 1'b0, 4'h0, 32'h00028150}, // R1 R2 supervisor read
    '{32'hF1084150, 1'b1, 1'b1, 1'b0, 4'h0, 32'h00028150}, // R2 user write allowed
    '{32'h00405ABC, 1'b0, 1'b0, 1'b0, 4'h0, 32'h00033ABC}, // R5 supervisor ignores user bit
    '{32'h00405ABC, 1'b0, 1'b1, 1'b1, 4'h5, 32'h0},        // R4 user bit clear at first level
    '{32'h00800000, 1'b0, 1'b0, 1'b1, 4'h0, 32'h0},        // R3 missing first level
    '{32'hF1085010, 1'b1, 1'b1, 1'b1, 4'hF, 32'h0},        // R5 writable clear at second level
    '{32'hF1085010, 1'b1, 1'b0, 1'b0, 4'h0, 32'h00044010}, // R5 supervisor write ignores it
    '{32'hF1086000, 1'b0, 1'b1, 1'b1, 4'hC, 32'h0},        // R3 missing second level
    '{32'h00405ABC, 1'b1, 1'b1, 1'b1, 4'h7, 32'h0},        // R6 user write, first level
    '{32'h01409000, 1'b1, 1'b1, 1'b1, 4'h7, 32'h0},        // R5 writable clear at first level
    '{32'h01409000, 1'b0, 1'b1, 1'b0, 4'h0, 32'h00077000}  // R4 user read allowed
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] la, input logic wr, input logic usr);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = la; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11 busy after accept", {31'b0, req_ready}, 32'h0);
    n = 0;
    while (!resp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(resp_valid, "R11 response arrives", {31'b0, resp_valid}, 32'h1);
  endtask

  task automatic load_root(input logic [31:0] v, input logic [1:0] ring);
    @(negedge clk);
    root_we = 1'b1; root_wdata = v; cur_ring = ring;
    @(negedge clk);
    root_we = 1'b0; cur_ring = 2'd3;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    // first level (root 0): word = index
    mem[11'h3C4] = 32'h00001007;
    mem[11'd1]   = 32'h00001003;
    mem[11'd4]   = 32'h00001007;
    mem[11'd5]   = 32'h00001005;
    // second level table at 0x1000: word = 1024 + index
    mem[1024 + 32'h84] = 32'h00028007;
    mem[1024 + 32'h85] = 32'h00044005;
    mem[1024 + 5]      = 32'h00033007;
    mem[1024 + 8]      = 32'h00066005;
    mem[1024 + 9]      = 32'h00077007;

    rst_n = 1'b0; root_we = 1'b0; root_wdata = '0; cur_ring = 2'd3;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, "R12 ready", {31'b0, req_ready}, 32'h1);
    check(resp_valid == 1'b0, "R12 no response", {31'b0, resp_valid}, 32'h0);
    check(!mem_rd_en && !mem_wr_en, "R12 no access", {30'b0, mem_rd_en, mem_wr_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      walk(VECS[v].la, VECS[v].wr, VECS[v].usr);
      check(resp_fault == VECS[v].fault, "R3 R4 R5 fault flag",
            {31'b0, resp_fault}, {31'b0, VECS[v].fault});
      check(resp_code == VECS[v].code, "R6 cause code",
            {28'b0, resp_code}, {28'b0, VECS[v].code});
      if (!VECS[v].fault)
        check(resp_paddr == VECS[v].pa, "R1 R2 physical address", resp_paddr, VECS[v].pa);
      @(negedge clk);
      check(resp_valid == 1'b0, "R11 single-cycle response", {31'b0, resp_valid}, 32'h0);
    end

    // R7 R8: flag write-back results
    check(mem[11'h3C4] == 32'h00001027, "R7 first level accessed", mem[11'h3C4], 32'h00001027);
    check(mem[1024 + 32'h84] == 32'h00028067, "R8 dirty after user write",
          mem[1024 + 32'h84], 32'h00028067);
    check(mem[1024 + 32'h85] == 32'h00044065, "R8 dirty after supervisor write",
          mem[1024 + 32'h85], 32'h00044065);
    check(mem[1024 + 5] == 32'h00033027, "R8 read leaves dirty clear",
          mem[1024 + 5], 32'h00033027);
    check(mem[1] == 32'h00001023, "R7 accessed only, no dirty at first level",
          mem[1], 32'h00001023);

    // R9: faulting walk leaves both entries untouched
    walk(32'h01008000, 1'b1, 1'b1);
    check(resp_fault && resp_code == 4'hF, "R9 fault seen", {28'b0, resp_code}, 32'hF);
    @(negedge clk);
    check(mem[4] == 32'h00001007, "R9 first level unchanged", mem[4], 32'h00001007);
    check(mem[1024 + 8] == 32'h00066005, "R9 second level unchanged",
          mem[1024 + 8], 32'h00066005);

    // R10: ring 3 load ignored, ring 0 load applied
    load_root(32'h00001000, 2'd3);
    walk(32'hF1084150, 1'b0, 1'b0);
    check(!resp_fault && resp_paddr == 32'h00028150, "R10 ring 3 load ignored",
          resp_paddr, 32'h00028150);
    load_root(32'h00001ABC, 2'd0);
    walk(32'hF1084150, 1'b0, 1'b0);
    check(resp_fault && resp_code == 4'h0, "R10 ring 0 load redirects walk (R1 aligned root)",
          {27'b0, resp_fault, resp_code}, 32'h10);
    load_root(32'h00000000, 2'd0);
    walk(32'hF1084150, 1'b0, 1'b0);
    check(!resp_fault && resp_paddr == 32'h00028150, "R10 root restored",
          resp_paddr, 32'h00028150);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule